// File: doc/BRIEF.md
# Interrupt Request Detector for an 8-bit Core

This block stands between two external active-low interrupt pins and the control sequencer of a small 8-bit processor. It tells the core, at each instruction boundary, whether to start a non-maskable interrupt sequence, a maskable interrupt sequence, or neither. The core reports the boundary with a one-cycle strobe and passes in its status byte. It acknowledges a non-maskable interrupt when it begins servicing it.

The non-maskable pin is edge-triggered. Each pin passes through a synchroniser. A register holds the previous synchronised level of the non-maskable pin, and a falling edge sets a pending flag. That flag stays set until the core acknowledges it. A low level held on the pin never produces a second request. The maskable pin is level-triggered. While its synchronised level is low and the interrupt-disable bit of the status byte is clear, it is offered again at every boundary. The non-maskable request always has priority.

Top module: `intr_boundary_detect`

## Requirements
- R1: After reset no NMI is pending and both request outputs are low. If the NMI pin is held high through reset and afterwards, no request is produced.
- R2: A high-to-low change on `nmi_pin_n` sets the pending NMI. With two synchroniser stages, a pin change driven before clock edge k makes `take_nmi` available from clock edge k+2 onward.
- R3: While the NMI pin stays low, the NMI is requested once only. After it is acknowledged, later boundaries give `take_nmi` = 0 until the pin returns high and falls again.
- R4: A new fall of the NMI pin after it has returned high produces a new NMI request.
- R5: `nmi_ack` high at a clock edge clears the pending NMI. If a falling edge is detected at that same clock edge, the edge wins and the NMI stays pending.
- R6: The IRQ level is seen two clock edges after the pin changes. `take_irq` is raised at every boundary while that level is low, no NMI is pending and the disable bit is clear.
- R7: `cpu_status` bit 2 set masks the IRQ. Clearing bit 2 while the IRQ pin is still low raises `take_irq` again at the boundary. The other status bits have no effect.
- R8: When an NMI is pending and the IRQ is also active at a boundary, only `take_nmi` is high.
- R9: Both request outputs are low whenever `at_boundary` is low.
- R10: At most one of `take_nmi` and `take_irq` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_pin_n | input | 1 | Non-maskable interrupt pin, active low, asynchronous |
| irq_pin_n | input | 1 | Maskable interrupt pin, active low, asynchronous |
| cpu_status | input | 8 | Processor status byte; bit 2 disables the IRQ |
| at_boundary | input | 1 | One-cycle strobe at each instruction boundary |
| nmi_ack | input | 1 | Core starts the NMI sequence; clears the pending NMI |
| take_nmi | output | 1 | Start the NMI sequence at this boundary |
| take_irq | output | 1 | Start the IRQ sequence at this boundary |

## Verification
The acknowledge and clear properties assume that `nmi_ack` appears only while the core really starts an NMI. The bench raises it only in the cycle after a `take_nmi` grant, apart from one deliberate overlap with a detected edge. The grant properties assume that `cpu_status` and `at_boundary` are held stable between clock edges. The bench changes all inputs on the falling clock edge only. It keeps every pin pulse longer than the synchroniser depth, so that each edge the bench expects is seen by the design.

// File: rtl/intr_pkg.sv
package intr_pkg;

    // Register state of the edge latch
    typedef struct packed {
        logic prev;   // previous synchronised pin level, resets high
        logic pend;   // NMI waiting for the core
    } nmi_state_t;

    localparam int unsigned PIN_COUNT = 2;
    localparam int unsigned PIN_NMI   = 0;
    localparam int unsigned PIN_IRQ   = 1;

endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    // Each stage resets to the inactive (high) pin level
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '1;
            else        stage_q[g] <= stage_d[g];
        end
    end

    assign dout = stage_q[LAST];
endmodule

// File: rtl/intr_nmi_latch.sv
module intr_nmi_latch
    import intr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_lvl,    // synchronised pin, active low
    input  logic nmi_ack,
    output logic nmi_pend
);
    nmi_state_t st_d;
    nmi_state_t st_q;
    logic       fall;

    always_comb begin
        fall      = st_q.prev & ~nmi_lvl;
        st_d.prev = nmi_lvl;
        // A fresh edge beats a simultaneous acknowledge
        st_d.pend = fall | (st_q.pend & ~nmi_ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nmi_pend = st_q.pend;
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter #(
    parameter int unsigned STATUS_W = 8,
    parameter int unsigned MASK_BIT = 2
) (
    input  logic                at_boundary,
    input  logic                nmi_pend,
    input  logic                irq_lvl,      // synchronised pin, active low
    input  logic [STATUS_W-1:0] cpu_status,
    output logic                take_nmi,
    output logic                take_irq
);
    logic irq_live;

    always_comb begin
        irq_live = ~irq_lvl & ~cpu_status[MASK_BIT];
        take_nmi = at_boundary & nmi_pend;
        take_irq = at_boundary & ~nmi_pend & irq_live;
    end
endmodule

// File: rtl/intr_boundary_detect.sv
module intr_boundary_detect
    import intr_pkg::*;
#(
    parameter int unsigned STATUS_W    = 8,
    parameter int unsigned MASK_BIT    = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nmi_pin_n,
    input  logic                irq_pin_n,
    input  logic [STATUS_W-1:0] cpu_status,
    input  logic                at_boundary,
    input  logic                nmi_ack,
    output logic                take_nmi,
    output logic                take_irq
);
    logic [PIN_COUNT-1:0] pins_raw;
    logic [PIN_COUNT-1:0] pins_sync;
    logic                 nmi_lvl;
    logic                 irq_lvl;
    logic                 nmi_pend;

    assign pins_raw[PIN_NMI] = nmi_pin_n;
    assign pins_raw[PIN_IRQ] = irq_pin_n;

    intr_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_sync)
    );

    assign nmi_lvl = pins_sync[PIN_NMI];
    assign irq_lvl = pins_sync[PIN_IRQ];

    intr_nmi_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_lvl (nmi_lvl),
        .nmi_ack (nmi_ack),
        .nmi_pend(nmi_pend)
    );

    intr_arbiter #(.STATUS_W(STATUS_W), .MASK_BIT(MASK_BIT)) u_arb (
        .at_boundary(at_boundary),
        .nmi_pend   (nmi_pend),
        .irq_lvl    (irq_lvl),
        .cpu_status (cpu_status),
        .take_nmi   (take_nmi),
        .take_irq   (take_irq)
    );
endmodule

// File: rtl/intr_boundary_detect_chk.sv
module intr_boundary_detect_chk #(
    parameter int unsigned STATUS_W = 8,
    parameter int unsigned MASK_BIT = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [STATUS_W-1:0] cpu_status,
    input logic                at_boundary,
    input logic                nmi_ack,
    input logic                take_nmi,
    input logic                take_irq,
    input logic                nmi_lvl,
    input logic                nmi_pend
);
    AST_NMI_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |-> at_boundary); // R9
    AST_IRQ_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> at_boundary); // R9
    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_nmi, take_irq})); // R10
    AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> !nmi_pend); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> !cpu_status[MASK_BIT]); // R7
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !nmi_ack) |=> nmi_pend); // R3
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && nmi_ack && nmi_lvl) |=> !nmi_pend); // R5
    AST_NO_EDGE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_pend && nmi_lvl) |=> !nmi_pend); // R2
endmodule

bind intr_boundary_detect intr_boundary_detect_chk #(
    .STATUS_W(STATUS_W),
    .MASK_BIT(MASK_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_status (cpu_status),
    .at_boundary(at_boundary),
    .nmi_ack    (nmi_ack),
    .take_nmi   (take_nmi),
    .take_irq   (take_irq),
    .nmi_lvl    (nmi_lvl),
    .nmi_pend   (nmi_pend)
);

// File: tb/intr_boundary_detect_bench.sv
`timescale 1ns/100ps
module intr_boundary_detect_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_pin_n = 1'b1;
    logic       irq_pin_n = 1'b1;
    logic [7:0] cpu_status = 8'h00;
    logic       at_boundary = 1'b0;
    logic       nmi_ack = 1'b0;
    logic       take_nmi;
    logic       take_irq;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    intr_boundary_detect u_intr_boundary_detect (
        .clk(clk), .rst_n(rst_n), .nmi_pin_n(nmi_pin_n), .irq_pin_n(irq_pin_n),
        .cpu_status(cpu_status), .at_boundary(at_boundary), .nmi_ack(nmi_ack),
        .take_nmi(take_nmi), .take_irq(take_irq)
    );

    // Behavioural reference: pin history queues, no structural copy
    bit nq[$];
    bit iq[$];
    bit m_pend;
    bit m_irq_low_n;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nq = '{1'b1, 1'b1, 1'b1};
            iq = '{1'b1};
            m_pend = 1'b0;
            m_irq_low_n = 1'b1;
        end else begin
            m_pend = (nq[0] & ~nq[1]) | (m_pend & ~nmi_ack);
            m_irq_low_n = iq[0];
            nq.push_back(nmi_pin_n);
            void'(nq.pop_front());
            iq.push_back(irq_pin_n);
            void'(iq.pop_front());
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic e_nmi, e_irq;
            e_nmi = at_boundary & m_pend;
            e_irq = at_boundary & ~m_pend & ~m_irq_low_n & ~cpu_status[2];
            total++;
            if (take_nmi !== e_nmi || take_irq !== e_irq) begin
                bad++;
                $display("FAIL %s model: got nmi=%0b irq=%0b exp nmi=%0b irq=%0b",
                         cur_req, take_nmi, take_irq, e_nmi, e_irq);
            end
        end
    end

    task automatic chk(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
        end
    endtask

    task automatic nx();
        @(negedge clk);
    endtask

    initial begin
        #20000;
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) nx();
        rst_n = 1'b1;
        // R1: pins high through reset, no request
        cur_req = "R1";
        for (int i = 0; i < 4; i++) begin
            nx(); at_boundary = 1'b1; #1;
            chk(take_nmi, 1'b0, "R1 nmi"); chk(take_irq, 1'b0, "R1 irq");
        end
        // R2: edge latency
        cur_req = "R2";
        nx(); nmi_pin_n = 1'b0; at_boundary = 1'b0;
        nx(); at_boundary = 1'b1; #1; chk(take_nmi, 1'b0, "R2 early1");
        nx(); #1; chk(take_nmi, 1'b0, "R2 early2");
        nx(); #1; chk(take_nmi, 1'b1, "R2 taken");
        nmi_ack = 1'b1;
        // R3: held low, no repeat
        cur_req = "R3";
        nx(); nmi_ack = 1'b0; #1; chk(take_nmi, 1'b0, "R3 after ack");
        for (int i = 0; i < 5; i++) begin
            nx(); #1; chk(take_nmi, 1'b0, "R3 held low");
        end
        // R4: re-arm by high then low
        cur_req = "R4";
        nx(); nmi_pin_n = 1'b1;
        repeat (3) nx();
        nx(); nmi_pin_n = 1'b0; at_boundary = 1'b0;
        nx(); nx();
        nx(); at_boundary = 1'b1; #1; chk(take_nmi, 1'b1, "R4 second edge");
        nmi_ack = 1'b1;
        nx(); nmi_ack = 1'b0;
        // R5: ack coinciding with edge, then plain ack
        cur_req = "R5";
        nx(); nmi_pin_n = 1'b1;
        repeat (3) nx();
        nx(); nmi_pin_n = 1'b0; at_boundary = 1'b0;
        nx();
        nx(); nmi_ack = 1'b1;
        nx(); nmi_ack = 1'b0; at_boundary = 1'b1; #1; chk(take_nmi, 1'b1, "R5 edge beats ack");
        nmi_ack = 1'b1;
        nx(); nmi_ack = 1'b0; #1; chk(take_nmi, 1'b0, "R5 ack clears");
        // R6: IRQ level with two-edge latency, repeats
        cur_req = "R6";
        nx(); irq_pin_n = 1'b0; #1; chk(take_irq, 1'b0, "R6 early0");
        nx(); #1; chk(take_irq, 1'b0, "R6 early1");
        nx(); #1; chk(take_irq, 1'b1, "R6 level seen");
        for (int i = 0; i < 3; i++) begin
            nx(); #1; chk(take_irq, 1'b1, "R6 repeats");
        end
        // R9: no boundary, no output
        cur_req = "R9";
        nx(); at_boundary = 1'b0; #1;
        chk(take_irq, 1'b0, "R9 irq"); chk(take_nmi, 1'b0, "R9 nmi");
        // R7: masking by bit 2 only
        cur_req = "R7";
        nx(); at_boundary = 1'b1; cpu_status = 8'h04; #1; chk(take_irq, 1'b0, "R7 masked");
        nx(); cpu_status = 8'hFB; #1; chk(take_irq, 1'b1, "R7 unmasked others set");
        nx(); cpu_status = 8'h00;
        // R8: NMI priority over active IRQ
        cur_req = "R8";
        nx(); nmi_pin_n = 1'b1;
        repeat (3) nx();
        nx(); nmi_pin_n = 1'b0;
        nx(); #1; chk(take_irq, 1'b1, "R8 irq before nmi");
        nx();
        nx(); #1; chk(take_nmi, 1'b1, "R8 nmi"); chk(take_irq, 1'b0, "R8 irq held off");
        nmi_ack = 1'b1;
        nx(); nmi_ack = 1'b0; #1; chk(take_irq, 1'b1, "R8 irq resumes");
        // R6: release IRQ
        cur_req = "R6";
        nx(); irq_pin_n = 1'b1;
        nx(); nx(); #1; chk(take_irq, 1'b0, "R6 released");
        nx();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule